// File: doc/BRIEF.md
# Scratchpad-Backed Mutex Manager

This block serves lock and unlock requests for mutex primitives whose state lives in a local single-port scratchpad. Each primitive has a three-word control record at a word address given with the request. The first word is an identity word that this block does not touch. The next word holds the head and tail pointers of a queue of blocked threads. The last word holds the owner of the mutex.

A lock on a free mutex makes the requester the owner at once and raises a reply that carries its thread code. A lock on a held mutex takes a queue entry from a pool of entries in the scratchpad and appends the requester to the tail of that primitive's wait list. No reply is raised in that case. An unlock from the owner hands the mutex to the thread at the head of the list and raises a reply for that thread. If no thread is waiting, the unlock only clears the owner.

Only one request is in progress at a time. The scratchpad is driven one access at a time and returns read data a fixed number of cycles after each access.

Top module: `mtx_manager`

## Requirements
- R1: `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low from the cycle after that edge until processing finishes, and the first scratchpad access is a read issued in that cycle.
- R2: The scratchpad word at `ptr+2` holds the owner in bits [15:0], where 16'h0000 means unlocked. Bits [31:16] of that word are preserved by every write.
- R3: A lock on an unlocked mutex performs exactly two scratchpad accesses: a read of `ptr+2`, then a write of the requester's code into the owner field. `rsp_valid` then pulses for one cycle with `rsp_tid` equal to the requester. The pulse comes 6 cycles after the first cycle following acceptance.
- R4: The scratchpad has a read latency of LAT=2 cycles. At most one access is outstanding, so successive accesses are at least LAT+1 cycles apart.
- R5: A lock on a held mutex takes the lowest free queue entry, whose address is QBASE+index, and writes {16'h0, tid} into it. The word at `ptr+1` holds the head in [31:16] and the tail in [15:0], with 0 meaning nil. If the queue was empty, both head and tail are set to the new entry. Otherwise the old tail entry's next field [31:16] and the tail field are both set to the new entry. The owner field is unchanged and no reply is raised.
- R6: An unlock by the owner with waiters makes the head entry's thread the owner. The head is advanced to that entry's next field, and the tail becomes 0 when the next field is 0. The entry is returned to the pool, and a reply pulse carries the new owner's code.
- R7: An unlock by the owner with no waiters writes the owner field to 0 and raises no reply.
- R8: An unlock whose thread code differs from the owner field, including an unlock of a free mutex, raises a one-cycle `err` pulse. It writes nothing and raises no reply.
- R9: A lock on a held mutex while every queue entry is in use raises `err`. It writes nothing and raises no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_op | input | 1 | 0 lock, 1 unlock |
| req_ptr | input | 16 | Word address of the control record |
| req_tid | input | 16 | Thread code (nonzero) |
| mem_en | output | 1 | Scratchpad access strobe |
| mem_we | output | 1 | Write when high, read when low |
| mem_addr | output | AW | Scratchpad word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid LAT cycles after the strobe |
| rsp_valid | output | 1 | Reply ready, one-cycle pulse |
| rsp_tid | output | 16 | Thread granted ownership |
| err | output | 1 | Rejected request, one-cycle pulse |

## Verification
The hardest state to reach is a full wait pool. The bench reaches it by locking one mutex and then queuing one more thread than there are entries. It then checks that the rejected request writes nothing. Next it releases the head entry and queues a new thread. That new thread must reuse the lowest entry and be linked behind the entry that was the tail, which exercises the pool reuse and the non-empty append path together. Ownership handover is driven through a chain of two waiters, so the path that empties the queue and clears the tail is also covered.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
    localparam int unsigned FW = 16;
    localparam int unsigned DW = 32;

    typedef enum logic {
        OP_LOCK   = 1'b0,
        OP_UNLOCK = 1'b1
    } mtx_op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_L_VAL,
        S_L_OWN,
        S_L_ENT,
        S_L_HT,
        S_L_TRD,
        S_L_TWR,
        S_L_HTW,
        S_U_VAL,
        S_U_HT,
        S_U_HEAD,
        S_U_VWR,
        S_U_HTW,
        S_REPLY,
        S_ERR
    } mtx_state_e;

    typedef struct packed {
        mtx_state_e    st;
        logic [FW-1:0] ptr;
        logic [FW-1:0] tid;
        logic [FW-1:0] ent;
        logic [FW-1:0] head;
        logic [FW-1:0] tail;
        logic [FW-1:0] owner;
        logic [FW-1:0] vhi;
        logic [FW-1:0] tlow;
        logic          hand;
    } mtx_regs_t;
endpackage

// File: rtl/mtx_memseq.sv
module mtx_memseq #(
    parameter int unsigned AW  = 8,
    parameter int unsigned LAT = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          done,
    output logic [31:0]   rdata
);
    localparam int unsigned CW = $clog2(LAT + 1);

    logic          busy_d, busy_q;
    logic [CW-1:0] cnt_d, cnt_q;

    assign mem_en    = start && !busy_q;
    assign mem_we    = we;
    assign mem_addr  = addr;
    assign mem_wdata = wdata;
    assign done      = busy_q && (cnt_q == CW'(LAT));
    assign rdata     = mem_rdata;

    always_comb begin
        busy_d = busy_q;
        cnt_d  = cnt_q;
        if (mem_en) begin
            busy_d = 1'b1;
            cnt_d  = CW'(1);
        end else if (done) begin
            busy_d = 1'b0;
            cnt_d  = '0;
        end else if (busy_q) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            busy_q <= busy_d;
            cnt_q  <= cnt_d;
        end
    end
endmodule

// File: rtl/mtx_freelist.sv
module mtx_freelist #(
    parameter int unsigned NQ = 8,
    localparam int unsigned IW = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic          rel,
    input  logic [IW-1:0] rel_idx,
    output logic [IW-1:0] idx,
    output logic          full
);
    logic [NQ-1:0] used_d, used_q;

    always_comb begin
        idx = '0;
        for (int i = NQ - 1; i >= 0; i--) begin
            if (!used_q[i]) idx = IW'(i);
        end
    end

    assign full = &used_q;

    for (genvar g = 0; g < NQ; g++) begin : g_slot
        always_comb begin
            used_d[g] = used_q[g];
            if (take && !full && (idx == IW'(g))) used_d[g] = 1'b1;
            if (rel && (rel_idx == IW'(g)))       used_d[g] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) used_q <= '0;
        else        used_q <= used_d;
    end
endmodule

// File: rtl/mtx_manager.sv
module mtx_manager
    import mtx_pkg::*;
#(
    parameter int unsigned AW    = 8,
    parameter int unsigned NQ    = 8,
    parameter int unsigned QBASE = 64,
    parameter int unsigned LAT   = 2,
    localparam int unsigned IW   = (NQ > 1) ? $clog2(NQ) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_op,
    input  logic [15:0]   req_ptr,
    input  logic [15:0]   req_tid,
    output logic          mem_en,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          rsp_valid,
    output logic [15:0]   rsp_tid,
    output logic          err
);
    mtx_regs_t r_d, r_q;

    logic          start, we, done;
    logic [AW-1:0] addr;
    logic [31:0]   wdata, rdata;
    logic          take, rel, full;
    logic [IW-1:0] rel_idx, fidx;

    logic [AW-1:0] a_ht, a_val;
    assign a_ht  = AW'(r_q.ptr) + AW'(1);
    assign a_val = AW'(r_q.ptr) + AW'(2);

    mtx_memseq #(.AW(AW), .LAT(LAT)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .we(we), .addr(addr),
        .wdata(wdata), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .done(done), .rdata(rdata)
    );

    mtx_freelist #(.NQ(NQ)) i_free (
        .clk(clk), .rst_n(rst_n), .take(take), .rel(rel), .rel_idx(rel_idx),
        .idx(fidx), .full(full)
    );

    assign req_ready = (r_q.st == S_IDLE);
    assign rsp_valid = (r_q.st == S_REPLY);
    assign err       = (r_q.st == S_ERR);
    assign rsp_tid   = r_q.owner;

    always_comb begin
        r_d     = r_q;
        start   = 1'b0;
        we      = 1'b0;
        addr    = '0;
        wdata   = '0;
        take    = 1'b0;
        rel     = 1'b0;
        rel_idx = IW'(r_q.head - FW'(QBASE));
        unique case (r_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    r_d.ptr  = req_ptr;
                    r_d.tid  = req_tid;
                    r_d.hand = 1'b0;
                    r_d.st   = (mtx_op_e'(req_op) == OP_LOCK) ? S_L_VAL : S_U_VAL;
                end
            end
            S_L_VAL: begin
                start = 1'b1;
                addr  = a_val;
                if (done) begin
                    r_d.vhi = rdata[31:16];
                    if (rdata[15:0] == '0) begin
                        r_d.owner = r_q.tid;
                        r_d.st    = S_L_OWN;
                    end else if (full) begin
                        r_d.st = S_ERR;
                    end else begin
                        take    = 1'b1;
                        r_d.ent = FW'(QBASE) + FW'(fidx);
                        r_d.st  = S_L_ENT;
                    end
                end
            end
            S_L_OWN: begin
                start = 1'b1;
                we    = 1'b1;
                addr  = a_val;
                wdata = {r_q.vhi, r_q.tid};
                if (done) r_d.st = S_REPLY;
            end
            S_L_ENT: begin
                start = 1'b1;
                we    = 1'b1;
                addr  = AW'(r_q.ent);
                wdata = {16'h0000, r_q.tid};
                if (done) r_d.st = S_L_HT;
            end
            S_L_HT: begin
                start = 1'b1;
                addr  = a_ht;
                if (done) begin
                    if (rdata[15:0] == '0) begin
                        r_d.head = r_q.ent;
                        r_d.tail = r_q.ent;
                        r_d.st   = S_L_HTW;
                    end else begin
                        r_d.head = rdata[31:16];
                        r_d.tail = rdata[15:0];
                        r_d.st   = S_L_TRD;
                    end
                end
            end
            S_L_TRD: begin
                start = 1'b1;
                addr  = AW'(r_q.tail);
                if (done) begin
                    r_d.tlow = rdata[15:0];
                    r_d.st   = S_L_TWR;
                end
            end
            S_L_TWR: begin
                start = 1'b1;
                we    = 1'b1;
                addr  = AW'(r_q.tail);
                wdata = {r_q.ent, r_q.tlow};
                if (done) begin
                    r_d.tail = r_q.ent;
                    r_d.st   = S_L_HTW;
                end
            end
            S_L_HTW: begin
                start = 1'b1;
                we    = 1'b1;
                addr  = a_ht;
                wdata = {r_q.head, r_q.tail};
                if (done) r_d.st = S_IDLE;
            end
            S_U_VAL: begin
                start = 1'b1;
                addr  = a_val;
                if (done) begin
                    r_d.vhi = rdata[31:16];
                    r_d.st  = (rdata[15:0] == r_q.tid) ? S_U_HT : S_ERR;
                end
            end
            S_U_HT: begin
                start = 1'b1;
                addr  = a_ht;
                if (done) begin
                    r_d.head = rdata[31:16];
                    r_d.tail = rdata[15:0];
                    if (rdata[31:16] == '0) begin
                        r_d.owner = '0;
                        r_d.st    = S_U_VWR;
                    end else begin
                        r_d.st = S_U_HEAD;
                    end
                end
            end
            S_U_HEAD: begin
                start = 1'b1;
                addr  = AW'(r_q.head);
                if (done) begin
                    rel       = 1'b1;
                    r_d.owner = rdata[15:0];
                    r_d.head  = rdata[31:16];
                    r_d.tail  = (rdata[31:16] == '0) ? '0 : r_q.tail;
                    r_d.hand  = 1'b1;
                    r_d.st    = S_U_VWR;
                end
            end
            S_U_VWR: begin
                start = 1'b1;
                we    = 1'b1;
                addr  = a_val;
                wdata = {r_q.vhi, r_q.owner};
                if (done) r_d.st = r_q.hand ? S_U_HTW : S_IDLE;
            end
            S_U_HTW: begin
                start = 1'b1;
                we    = 1'b1;
                addr  = a_ht;
                wdata = {r_q.head, r_q.tail};
                if (done) r_d.st = S_REPLY;
            end
            S_REPLY: r_d.st = S_IDLE;
            S_ERR:   r_d.st = S_IDLE;
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= S_IDLE;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/mtx_manager_chk.sv
module mtx_manager_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic mem_en,
    input logic mem_we,
    input logic rsp_valid,
    input logic err
);
    // R1
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R1
    first_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (mem_en && !mem_we));
    // R4
    one_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !mem_en);
    // R3
    reply_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
    // R3
    reply_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!req_ready && !err));
    // R8
    err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> (!err && req_ready));
    // R8
    err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !mem_en);
endmodule

bind mtx_manager mtx_manager_chk i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .mem_en(mem_en), .mem_we(mem_we), .rsp_valid(rsp_valid), .err(err)
);

// File: tb/test_mtx_manager.sv
module test_mtx_manager;
    localparam int unsigned AW = 8;
    localparam int unsigned NQ = 8;
    localparam int unsigned QB = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_op = 1'b0;
    logic [15:0]   req_ptr = '0;
    logic [15:0]   req_tid = '0;
    logic          mem_en, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0]   mem_wdata, mem_rdata;
    logic          rsp_valid, err;
    logic [15:0]   rsp_tid;

    always #10 clk = ~clk;

    mtx_manager #(.AW(AW), .NQ(NQ), .QBASE(QB), .LAT(2)) i_mtx_manager (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_ptr(req_ptr), .req_tid(req_tid),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rsp_valid(rsp_valid), .rsp_tid(rsp_tid), .err(err)
    );

    logic [31:0] mem [0:(1<<AW)-1];
    logic [31:0] p1, p2;
    always @(posedge clk) begin
        if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
        p1 <= mem[mem_addr];
        p2 <= p1;
    end
    assign mem_rdata = p2;

    int cyc = 0, n_chk = 0, n_fail = 0;
    int n_rsp = 0, n_err = 0, n_acc = 0, n_wr = 0, rsp_cyc = 0, last_acc = -100, gap_bad = 0;
    logic [15:0] last_tid = '0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin n_rsp++; last_tid = rsp_tid; rsp_cyc = cyc; end
            if (err) n_err++;
            if (mem_en) begin
                if (cyc - last_acc < 3) gap_bad++;
                last_acc = cyc;
                n_acc++;
                if (mem_we) n_wr++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    int d_rsp, d_err, d_acc, d_wr, acc_cyc;

    task automatic do_req(input logic op, input logic [15:0] ptr, input logic [15:0] tid);
        int s_rsp, s_err, s_acc, s_wr;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_ptr = ptr; req_tid = tid;
        s_rsp = n_rsp; s_err = n_err; s_acc = n_acc; s_wr = n_wr;
        @(negedge clk);
        req_valid = 1'b0;
        acc_cyc = cyc;
        chk(req_ready == 1'b0, "R1 busy after accept", {31'd0, req_ready}, 32'd0);
        while (!req_ready) @(negedge clk);
        d_rsp = n_rsp - s_rsp; d_err = n_err - s_err;
        d_acc = n_acc - s_acc; d_wr = n_wr - s_wr;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 reset ready", {31'd0, req_ready}, 32'd1);
        chk(!rsp_valid && !err && !mem_en, "R1 reset quiet", {29'd0, rsp_valid, err, mem_en}, 32'd0);
    endtask

    task automatic t_lock_free();
        do_req(1'b0, 16'd4, 16'h0011);
        chk(d_rsp == 1 && last_tid == 16'h0011, "R3 grant reply", {16'd0, last_tid}, 32'h11);
        chk(rsp_cyc - acc_cyc == 6, "R3 reply timing", rsp_cyc - acc_cyc, 32'd6);
        chk(d_acc == 2, "R3 two accesses", d_acc, 32'd2);
        chk(mem[6] == 32'hABCD_0011, "R2 owner write", mem[6], 32'hABCD_0011);
    endtask

    task automatic t_enqueue();
        do_req(1'b0, 16'd4, 16'h0022);
        chk(d_rsp == 0 && d_err == 0, "R5 no reply", d_rsp, 32'd0);
        chk(mem[64] == 32'h0000_0022, "R5 entry", mem[64], 32'h22);
        chk(mem[5] == 32'h0040_0040, "R5 empty append", mem[5], 32'h0040_0040);
        chk(mem[6] == 32'hABCD_0011, "R5 owner kept", mem[6], 32'hABCD_0011);
        do_req(1'b0, 16'd4, 16'h0033);
        chk(mem[65] == 32'h0000_0033, "R5 entry2", mem[65], 32'h33);
        chk(mem[64] == 32'h0041_0022, "R5 link", mem[64], 32'h0041_0022);
        chk(mem[5] == 32'h0040_0041, "R5 tail", mem[5], 32'h0040_0041);
    endtask

    task automatic t_bad_unlock();
        do_req(1'b1, 16'd4, 16'h0022);
        chk(d_err == 1 && d_rsp == 0, "R8 non-owner err", d_err, 32'd1);
        chk(d_wr == 0 && mem[6] == 32'hABCD_0011, "R8 no write", d_wr, 32'd0);
    endtask

    task automatic t_handover();
        do_req(1'b1, 16'd4, 16'h0011);
        chk(d_rsp == 1 && last_tid == 16'h0022, "R6 handover1", {16'd0, last_tid}, 32'h22);
        chk(mem[6] == 32'hABCD_0022 && mem[5] == 32'h0041_0041, "R6 state1", mem[5], 32'h0041_0041);
        do_req(1'b1, 16'd4, 16'h0022);
        chk(d_rsp == 1 && last_tid == 16'h0033, "R6 handover2", {16'd0, last_tid}, 32'h33);
        chk(mem[5] == 32'h0, "R6 queue emptied", mem[5], 32'h0);
        do_req(1'b1, 16'd4, 16'h0033);
        chk(d_rsp == 0 && d_err == 0, "R7 no reply", d_rsp, 32'd0);
        chk(mem[6] == 32'hABCD_0000, "R7 owner cleared", mem[6], 32'hABCD_0000);
        do_req(1'b1, 16'd4, 16'h0033);
        chk(d_err == 1 && d_wr == 0, "R8 free unlock err", d_err, 32'd1);
    endtask

    task automatic t_full();
        do_req(1'b0, 16'd16, 16'h0100);
        chk(d_rsp == 1 && last_tid == 16'h0100, "R3 grant B", {16'd0, last_tid}, 32'h100);
        for (int i = 1; i <= NQ; i++) do_req(1'b0, 16'd16, 16'(16'h0200 + i));
        chk(mem[17] == 32'h0040_0047, "R5 full queue", mem[17], 32'h0040_0047);
        do_req(1'b0, 16'd16, 16'h0209);
        chk(d_err == 1 && d_rsp == 0 && d_wr == 0, "R9 pool full", {d_err[7:0], d_wr[7:0]}, 32'h0100);
        do_req(1'b1, 16'd16, 16'h0100);
        chk(d_rsp == 1 && last_tid == 16'h0201, "R6 handover B", {16'd0, last_tid}, 32'h201);
        do_req(1'b0, 16'd16, 16'h0209);
        chk(mem[64] == 32'h0000_0209, "R5 reuse lowest", mem[64], 32'h209);
        chk(mem[71] == 32'h0040_0208, "R5 link reuse", mem[71], 32'h0040_0208);
        chk(mem[17] == 32'h0041_0040, "R5 head/tail reuse", mem[17], 32'h0041_0040);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mem[i] = 32'h0;
        mem[4]  = 32'h8000_0004;
        mem[6]  = 32'hABCD_0000;
        mem[16] = 32'h8000_0010;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lock_free();
        t_enqueue();
        t_bad_unlock();
        t_handover();
        t_full();
        chk(gap_bad == 0, "R4 access spacing", gap_bad, 32'd0);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end
endmodule